// File: doc/BRIEF.md
# Prioritized Exception Dispatch Unit

This block holds a vector of pending exception flags together with the processor's machine state register (MSR), current program counter and next program counter. Each time the dispatch strobe is raised, it picks the most urgent pending exception, saves the return address and a masked copy of the MSR into the two save/restore registers (SRR0, SRR1), rewrites the MSR into its handler state and points both program counters at the handler vector. Synchronous faults are always considered first. The external-class events (external interrupt, performance monitor, decrementer) are considered only when the MSR external-enable bit is set; otherwise they stay pending.

A memory-check hit is a special entry: it saves no state and moves no program counter. It only clears its own flag and any pending data-storage flag. New requests are ORed into the pending vector on every clock, including the cycle in which a flag is being cleared, so no request is lost. A context-load port lets the surrounding core set the MSR and both program counters.

A three-state outcome machine records what the last clock edge did. `S_IDLE` means no dispatch took effect. `S_TAKEN` means a handler entry was committed. `S_CANCEL` means a memory-check hit was consumed. On every clock the next state is chosen from the current inputs, whatever the present state. It is `S_TAKEN` when a dispatch finds an eligible entry other than the memory-check hit. It is `S_CANCEL` when the winner is the memory-check hit. It is `S_IDLE` when there is no dispatch or no eligible entry.

Top module: `exc_dispatch_unit`

## Requirements
- R1: While reset is asserted and right after it, the pending vector, MSR, PC, next PC, SRR0, SRR1 and the vector output are zero, and the taken and cancel strobes are low.
- R2: Each request bit is ORed into the pending vector at the clock edge. It stays pending until dispatched. A request arriving on the same edge that clears that bit leaves the bit set.
- R3: Synchronous entries use these pending-bit positions, most urgent first: 0 instruction-storage, 1 program, 2 system call, 3 FPU-unavailable, 4 memory-check hit, 5 data-storage, 6 alignment.
- R4: External-class bits 7 (external), 8 (performance monitor) and 9 (decrementer) are dispatched only when MSR bit 15 is 1. Otherwise a dispatch with only these pending changes no state and raises no strobe.
- R5: Among eligible external-class bits, 7 beats 8 and 8 beats 9. All of them rank below every synchronous bit.
- R6: On a taken entry, SRR1 becomes MSR AND 0x87C0FFFF. Instruction-storage also sets bit 30, and program also sets bit 17 (0x20000).
- R7: On a taken entry, MSR bit 0 is loaded from MSR bit 16, and then the MSR is ANDed with the inverse of 0x0004EF36.
- R8: On a taken entry, PC, next PC and the vector output all become the handler vector: 0x400 instruction-storage, 0x700 program, 0xC00 system call, 0x800 FPU-unavailable, 0x300 data-storage, 0x600 alignment, 0x500 external, 0xF00 performance monitor, 0x900 decrementer.
- R9: SRR0 receives the next PC for instruction-storage, system call, external, performance monitor and decrementer. It receives the current PC for program, FPU-unavailable, data-storage and alignment.
- R10: A dispatched memory-check hit clears pending bits 4 and 5 only. It leaves MSR, PC, next PC, SRR0, SRR1 and the vector unchanged, pulses the cancel strobe for one cycle and keeps the taken strobe low.
- R11: A dispatch takes at most one entry and clears only that entry's pending bit. The taken strobe is high for exactly the cycle after each taken entry.
- R12: With the load input high and dispatch low, the MSR, PC and next PC take the load values at the clock edge. Whenever dispatch is high, the load input is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 10 | New exception requests, bit positions as in R3/R4 |
| dispatch_i | input | 1 | Perform one dispatch step at this edge |
| load_i | input | 1 | Load MSR, PC and next PC |
| load_msr_i | input | 32 | MSR value to load |
| load_pc_i | input | PC_W | Current PC value to load |
| load_npc_i | input | PC_W | Next PC value to load |
| pending_o | output | 10 | Pending exception flags |
| msr_o | output | 32 | Machine state register |
| pc_o | output | PC_W | Current PC |
| npc_o | output | PC_W | Next PC |
| srr0_o | output | PC_W | Saved return address |
| srr1_o | output | 32 | Saved machine state |
| taken_o | output | 1 | One-cycle strobe after a handler entry |
| cancel_o | output | 1 | One-cycle strobe after a memory-check cancel |
| vector_o | output | PC_W | Vector of the most recent taken entry |

## Verification
The bench builds the unit with the default program-counter width of 32 bits. At this width the save values and the vectors travel through the full register width, and the upper MSR bits that the SRR1 mask and the MSR clear mask act on can be exercised. A directed phase raises all ten flags at once and walks the priority ladder with external enable off and then on. This covers the memory-check cancel of a pending data-storage flag and a request colliding with its own clear. A long pseudo-random phase then mixes sparse requests, dispatches and context loads with random enable and interrupt-little-endian bits.

// File: rtl/exc_disp_pkg.sv
package exc_disp_pkg;
    localparam int NUM_EXC  = 10;
    localparam int NUM_SYNC = 7;
    localparam int IDX_W    = $clog2(NUM_EXC);

    localparam int IX_ISI  = 0;
    localparam int IX_PROG = 1;
    localparam int IX_SYSC = 2;
    localparam int IX_FPU  = 3;
    localparam int IX_MCHK = 4;
    localparam int IX_DSI  = 5;
    localparam int IX_ALGN = 6;
    localparam int IX_EXT  = 7;
    localparam int IX_PERF = 8;
    localparam int IX_DEC  = 9;

    localparam int MSR_LE_BIT  = 0;
    localparam int MSR_EE_BIT  = 15;
    localparam int MSR_ILE_BIT = 16;

    localparam logic [31:0] SAVE_KEEP = 32'h87C0_FFFF;
    localparam logic [31:0] MSR_CLEAR = 32'h0004_EF36;
    localparam logic [31:0] ISI_MARK  = 32'h4000_0000;
    localparam logic [31:0] PROG_MARK = 32'h0002_0000;

    typedef enum logic [1:0] {
        S_IDLE   = 2'd0,
        S_TAKEN  = 2'd1,
        S_CANCEL = 2'd2
    } disp_state_e;

    function automatic logic [11:0] handler_vec(input logic [IDX_W-1:0] idx);
        logic [11:0] v;
        case (idx)
            IDX_W'(IX_ISI):  v = 12'h400;
            IDX_W'(IX_PROG): v = 12'h700;
            IDX_W'(IX_SYSC): v = 12'hC00;
            IDX_W'(IX_FPU):  v = 12'h800;
            IDX_W'(IX_DSI):  v = 12'h300;
            IDX_W'(IX_ALGN): v = 12'h600;
            IDX_W'(IX_EXT):  v = 12'h500;
            IDX_W'(IX_PERF): v = 12'hF00;
            IDX_W'(IX_DEC):  v = 12'h900;
            default:         v = 12'h000;
        endcase
        return v;
    endfunction

    function automatic logic saves_next_pc(input logic [IDX_W-1:0] idx);
        return (idx == IDX_W'(IX_ISI))  || (idx == IDX_W'(IX_SYSC)) ||
               (idx == IDX_W'(IX_EXT))  || (idx == IDX_W'(IX_PERF)) ||
               (idx == IDX_W'(IX_DEC));
    endfunction
endpackage

// File: rtl/exc_prio_sel.sv
module exc_prio_sel
    import exc_disp_pkg::*;
#(
    parameter int N      = NUM_EXC,
    parameter int N_SYNC = NUM_SYNC,
    parameter int IW     = IDX_W
) (
    input  logic [N-1:0]  pend_i,
    input  logic          ext_en_i,
    output logic [N-1:0]  grant_o,
    output logic [IW-1:0] idx_o,
    output logic          vld_o
);
    logic [N-1:0] eligible;

    generate
        for (genvar g = 0; g < N; g++) begin : g_elig
            if (g < N_SYNC) begin : g_sync
                assign eligible[g] = pend_i[g];
            end else begin : g_ext
                assign eligible[g] = pend_i[g] & ext_en_i;
            end
        end
    endgenerate

    // Lowest index wins: scan from the top so the last hit is the most urgent.
    always_comb begin
        grant_o = '0;
        idx_o   = '0;
        vld_o   = 1'b0;
        for (int i = N - 1; i >= 0; i--) begin
            if (eligible[i]) begin
                grant_o    = '0;
                grant_o[i] = 1'b1;
                idx_o      = IW'(i);
                vld_o      = 1'b1;
            end
        end
    end
endmodule

// File: rtl/exc_save_calc.sv
module exc_save_calc
    import exc_disp_pkg::*;
#(
    parameter int PC_W = 32
) (
    input  logic [IDX_W-1:0] idx_i,
    input  logic [31:0]      msr_i,
    input  logic [PC_W-1:0]  pc_i,
    input  logic [PC_W-1:0]  npc_i,
    output logic [PC_W-1:0]  srr0_o,
    output logic [31:0]      srr1_o,
    output logic [31:0]      msr_o,
    output logic [PC_W-1:0]  vec_o
);
    localparam int PAD_W = PC_W - 12;

    logic [31:0] marks;
    logic [31:0] msr_le;

    always_comb begin
        marks = '0;
        if (idx_i == IDX_W'(IX_ISI))  marks = ISI_MARK;
        if (idx_i == IDX_W'(IX_PROG)) marks = PROG_MARK;
    end

    always_comb begin
        msr_le             = msr_i;
        msr_le[MSR_LE_BIT] = msr_i[MSR_ILE_BIT];
    end

    assign srr1_o = (msr_i & SAVE_KEEP) | marks;
    assign msr_o  = msr_le & ~MSR_CLEAR;
    assign srr0_o = saves_next_pc(idx_i) ? npc_i : pc_i;
    assign vec_o  = {{PAD_W{1'b0}}, handler_vec(idx_i)};
endmodule

// File: rtl/exc_dispatch_unit.sv
module exc_dispatch_unit
    import exc_disp_pkg::*;
#(
    parameter int PC_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_EXC-1:0]  req_i,
    input  logic                dispatch_i,
    input  logic                load_i,
    input  logic [31:0]         load_msr_i,
    input  logic [PC_W-1:0]     load_pc_i,
    input  logic [PC_W-1:0]     load_npc_i,
    output logic [NUM_EXC-1:0]  pending_o,
    output logic [31:0]         msr_o,
    output logic [PC_W-1:0]     pc_o,
    output logic [PC_W-1:0]     npc_o,
    output logic [PC_W-1:0]     srr0_o,
    output logic [31:0]         srr1_o,
    output logic                taken_o,
    output logic                cancel_o,
    output logic [PC_W-1:0]     vector_o
);
    disp_state_e state_q, state_d;

    logic [NUM_EXC-1:0] pend_q, pend_d, grant, clr_mask;
    logic [IDX_W-1:0]   win_idx;
    logic               win_vld;
    logic [31:0]        msr_q, srr1_q, nx_srr1, nx_msr;
    logic [PC_W-1:0]    pc_q, npc_q, srr0_q, vec_q, nx_srr0, nx_vec;
    logic               is_mchk, do_take, do_cancel;

    exc_prio_sel #(.N(NUM_EXC), .N_SYNC(NUM_SYNC), .IW(IDX_W)) u_sel (
        .pend_i   (pend_q),
        .ext_en_i (msr_q[MSR_EE_BIT]),
        .grant_o  (grant),
        .idx_o    (win_idx),
        .vld_o    (win_vld)
    );

    exc_save_calc #(.PC_W(PC_W)) u_save (
        .idx_i  (win_idx),
        .msr_i  (msr_q),
        .pc_i   (pc_q),
        .npc_i  (npc_q),
        .srr0_o (nx_srr0),
        .srr1_o (nx_srr1),
        .msr_o  (nx_msr),
        .vec_o  (nx_vec)
    );

    assign is_mchk   = (win_idx == IDX_W'(IX_MCHK));
    assign do_take   = dispatch_i && win_vld && !is_mchk;
    assign do_cancel = dispatch_i && win_vld && is_mchk;

    // Next outcome state.
    always_comb begin
        state_d = S_IDLE;
        unique case (1'b1)
            do_take:   state_d = S_TAKEN;
            do_cancel: state_d = S_CANCEL;
            default:   state_d = S_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // Strobe outputs decoded from the state.
    always_comb begin
        taken_o  = 1'b0;
        cancel_o = 1'b0;
        unique case (state_q)
            S_TAKEN:  taken_o  = 1'b1;
            S_CANCEL: cancel_o = 1'b1;
            default:  ;
        endcase
    end

    // Flags to drop this edge.
    always_comb begin
        clr_mask = '0;
        if (do_take) clr_mask = grant;
        if (do_cancel) begin
            clr_mask[IX_MCHK] = 1'b1;
            clr_mask[IX_DSI]  = 1'b1;
        end
    end

    generate
        for (genvar g = 0; g < NUM_EXC; g++) begin : g_pend
            assign pend_d[g] = (pend_q[g] & ~clr_mask[g]) | req_i[g];
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= '0;
            msr_q  <= '0;
            pc_q   <= '0;
            npc_q  <= '0;
            srr0_q <= '0;
            srr1_q <= '0;
            vec_q  <= '0;
        end else begin
            pend_q <= pend_d;
            if (do_take) begin
                srr0_q <= nx_srr0;
                srr1_q <= nx_srr1;
                msr_q  <= nx_msr;
                pc_q   <= nx_vec;
                npc_q  <= nx_vec;
                vec_q  <= nx_vec;
            end else if (load_i && !dispatch_i) begin
                msr_q <= load_msr_i;
                pc_q  <= load_pc_i;
                npc_q <= load_npc_i;
            end
        end
    end

    assign pending_o = pend_q;
    assign msr_o     = msr_q;
    assign pc_o      = pc_q;
    assign npc_o     = npc_q;
    assign srr0_o    = srr0_q;
    assign srr1_o    = srr1_q;
    assign vector_o  = vec_q;

    logic ext_win;
    assign ext_win = (win_idx >= IDX_W'(NUM_SYNC));

    a_r8_pc_at_vector: assert property (@(posedge clk) disable iff (!rst_n)
        taken_o |-> (pc_o == vector_o) && (npc_o == vector_o));

    a_r7_ee_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        taken_o |-> !msr_o[MSR_EE_BIT]);

    a_r6_srr1_marks: assert property (@(posedge clk) disable iff (!rst_n)
        taken_o |-> ((srr1_o & ~(SAVE_KEEP | ISI_MARK | PROG_MARK)) == 32'h0));

    a_r4_ext_needs_ee: assert property (@(posedge clk) disable iff (!rst_n)
        (do_take && ext_win) |-> msr_q[MSR_EE_BIT]);

    a_r10_cancel_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        cancel_o |-> $stable(pc_o) && $stable(srr0_o) && $stable(srr1_o) && $stable(msr_o));

    a_r2_no_loss: assert property (@(posedge clk) disable iff (!rst_n)
        !dispatch_i |=> ((pending_o & $past(pending_o)) == $past(pending_o)));

    a_r11_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !(taken_o && cancel_o));
endmodule

// File: tb/tb_exc_dispatch_unit.sv
`timescale 1ns/1ps
module tb_exc_dispatch_unit;
    localparam int PC_W = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [9:0]      req = '0;
    logic            disp = 1'b0, ld = 1'b0;
    logic [31:0]     ld_msr = '0;
    logic [PC_W-1:0] ld_pc = '0, ld_npc = '0;

    logic [9:0]      pending_o;
    logic [31:0]     msr_o, srr1_o;
    logic [PC_W-1:0] pc_o, npc_o, srr0_o, vector_o;
    logic            taken_o, cancel_o;

    exc_dispatch_unit #(.PC_W(PC_W)) dut (
        .clk(clk), .rst_n(rst_n), .req_i(req), .dispatch_i(disp), .load_i(ld),
        .load_msr_i(ld_msr), .load_pc_i(ld_pc), .load_npc_i(ld_npc),
        .pending_o(pending_o), .msr_o(msr_o), .pc_o(pc_o), .npc_o(npc_o),
        .srr0_o(srr0_o), .srr1_o(srr1_o), .taken_o(taken_o), .cancel_o(cancel_o),
        .vector_o(vector_o)
    );

    always #2.5 clk = ~clk;

    int total = 0;
    int bad = 0;
    bit done = 0;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // Behavioural reference model.
    logic [9:0]  m_pend;
    logic [31:0] m_msr, m_pc, m_npc, m_srr0, m_srr1, m_vec;
    logic        m_taken, m_cancel;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_pend = 0; m_msr = 0; m_pc = 0; m_npc = 0; m_srr0 = 0; m_srr1 = 0;
            m_vec = 0; m_taken = 0; m_cancel = 0;
        end else begin
            int pick;
            logic [9:0] p;
            p = m_pend;
            pick = -1;
            m_taken = 0;
            m_cancel = 0;
            if (disp) begin
                for (int i = 0; i < 7; i++) if (pick < 0 && p[i]) pick = i;
                if (pick < 0 && m_msr[15])
                    for (int i = 7; i < 10; i++) if (pick < 0 && p[i]) pick = i;
            end
            if (pick == 4) begin
                p[4] = 0; p[5] = 0; m_cancel = 1;
            end else if (pick >= 0) begin
                logic [31:0] v, nm;
                case (pick)
                    0: v = 32'h400; 1: v = 32'h700; 2: v = 32'hC00; 3: v = 32'h800;
                    5: v = 32'h300; 6: v = 32'h600; 7: v = 32'h500; 8: v = 32'hF00;
                    default: v = 32'h900;
                endcase
                m_srr1 = m_msr & 32'h87C0FFFF;
                if (pick == 0) m_srr1 = m_srr1 | 32'h40000000;
                if (pick == 1) m_srr1 = m_srr1 | 32'h00020000;
                if (pick == 1 || pick == 3 || pick == 5 || pick == 6) m_srr0 = m_pc;
                else m_srr0 = m_npc;
                nm = m_msr;
                nm[0] = m_msr[16];
                m_msr = nm & ~32'h0004EF36;
                m_pc = v; m_npc = v; m_vec = v;
                p[pick] = 0;
                m_taken = 1;
            end else if (ld && !disp) begin
                m_msr = ld_msr; m_pc = ld_pc; m_npc = ld_npc;
            end
            m_pend = p | req;
        end
    end

    // Compare on every clock, away from the active edge.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check("R2 pending", {22'd0, pending_o}, {22'd0, m_pend});
            check("R7 msr", msr_o, m_msr);
            check("R8 pc", pc_o, m_pc);
            check("R8 npc", npc_o, m_npc);
            check("R9 srr0", srr0_o, m_srr0);
            check("R6 srr1", srr1_o, m_srr1);
            check("R11 taken", {31'd0, taken_o}, {31'd0, m_taken});
            check("R10 cancel", {31'd0, cancel_o}, {31'd0, m_cancel});
            check("R8 vector", vector_o, m_vec);
        end
    end

    task automatic step(input logic [9:0] r, input logic d, input logic l,
                        input logic [31:0] m, input logic [31:0] p, input logic [31:0] n);
        req = r; disp = d; ld = l; ld_msr = m; ld_pc = p; ld_npc = n;
        @(negedge clk);
        req = '0; disp = 0; ld = 0;
    endtask

    initial begin
        #(200000 * 5);
        total++; bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] lf;
        lf = 32'h1ACE_2B3D;
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 pending", {22'd0, pending_o}, 32'h0);
        check("R1 msr", msr_o, 0);
        check("R1 pc", pc_o, 0);
        check("R1 npc", npc_o, 0);
        check("R1 srr", srr0_o | srr1_o | vector_o, 0);
        check("R1 strobes", {30'd0, taken_o, cancel_o}, 0);
        rst_n = 1;
        @(negedge clk);
        check("R1 after release", {22'd0, pending_o} | msr_o | pc_o, 0);

        step(0, 0, 1, 32'h0751_2B45, 32'h1000, 32'h1004);
        check("R12 load msr", msr_o, 32'h0751_2B45);
        check("R12 load pc", pc_o, 32'h1000);
        step(10'h3FF, 0, 0, 0, 0, 0);
        check("R2 all pending", {22'd0, pending_o}, 32'h3FF);

        step(0, 1, 0, 0, 0, 0);
        check("R3 isi vector", vector_o, 32'h400);
        check("R9 isi saves npc", srr0_o, 32'h1004);
        check("R6 isi srr1", srr1_o, 32'h4740_2B45);
        check("R7 msr update", msr_o, 32'h0751_0041);
        check("R8 pc=npc", pc_o ^ npc_o, 0);
        check("R11 taken", {31'd0, taken_o}, 1);
        check("R11 one cleared", {22'd0, pending_o}, 32'h3FE);
        step(0, 0, 0, 0, 0, 0);
        check("R11 strobe one cycle", {31'd0, taken_o}, 0);

        step(0, 1, 0, 0, 0, 0);
        check("R3 program vector", vector_o, 32'h700);
        check("R9 program saves pc", srr0_o, 32'h400);
        check("R6 program srr1", srr1_o, 32'h0742_0041);
        step(0, 1, 0, 0, 0, 0);
        check("R3 syscall vector", vector_o, 32'hC00);
        step(0, 1, 0, 0, 0, 0);
        check("R3 fpu vector", vector_o, 32'h800);
        step(0, 1, 0, 0, 0, 0);
        check("R10 cancel strobe", {30'd0, taken_o, cancel_o}, 32'h1);
        check("R10 clears dsi too", {22'd0, pending_o}, 32'h3C0);
        check("R10 pc unchanged", pc_o, 32'h800);
        step(0, 1, 0, 0, 0, 0);
        check("R3 alignment vector", vector_o, 32'h600);
        step(0, 1, 1, 32'h8000, 32'h3000, 32'h3004);
        check("R4 ext held", {22'd0, pending_o}, 32'h380);
        check("R4 no strobe", {31'd0, taken_o}, 0);
        check("R12 load ignored", pc_o, 32'h600);

        step(0, 0, 1, 32'h0000_8000, 32'h2000, 32'h2004);
        step(10'h080, 1, 0, 0, 0, 0);
        check("R5 external first", vector_o, 32'h500);
        check("R9 external saves npc", srr0_o, 32'h2004);
        check("R2 collide keeps bit", {22'd0, pending_o}, 32'h380);
        step(0, 0, 1, 32'h0000_8000, 32'h2000, 32'h2004);
        step(0, 1, 0, 0, 0, 0);
        check("R5 external again", vector_o, 32'h500);
        step(0, 0, 1, 32'h0000_8000, 32'h2000, 32'h2004);
        step(0, 1, 0, 0, 0, 0);
        check("R5 perf monitor", vector_o, 32'hF00);
        step(0, 0, 1, 32'h0000_8000, 32'h2000, 32'h2004);
        step(0, 1, 0, 0, 0, 0);
        check("R5 decrementer", vector_o, 32'h900);
        check("R5 all drained", {22'd0, pending_o}, 0);

        for (int k = 0; k < 4000; k++) begin
            logic [31:0] a, b;
            lf = {lf[30:0], 1'b0} ^ (lf[31] ? 32'h04C1_1DB7 : 32'h0);
            a = lf;
            lf = {lf[30:0], 1'b0} ^ (lf[31] ? 32'h04C1_1DB7 : 32'h0);
            b = lf;
            step((a[2:0] == 0) ? (10'd1 << (a[7:4] % 10)) : 10'd0,
                 a[8] & a[9], a[12:10] == 0, b, {a[31:16], 16'h0}, {a[31:16], 16'h4});
        end

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule